// File: doc/BRIEF.md
# Register-Indirect Branch Sequencer

This block runs one unconditional branch whose target comes from a register operand. Each branch request carries three independent control bits. The link bit writes the return PC into a destination register. The absolute bit picks the operand itself as the target, or the current PC plus the operand. The delay bit chooses whether the next sequential instruction runs before the target. The block takes a request while it is idle and captures the target and link data. It then either waits for the delay-slot instruction to retire, or counts fixed cycles and flushes the sequential fetch. At the end it issues a one-cycle redirect to the new PC.

While a branch is in flight, interrupt and hardware-break requests are held back. They are only accepted once the slot instruction has completed and the block is idle again. A request that links without a delay slot is rejected with the illegal flag. A slot instruction that is an immediate prefix, another branch or a break also raises the illegal flag, and that flag comes out with the redirect.

The controller has seven named states:
- `ST_IDLE` waits for a request.
- `ST_REJECT` takes one cycle to refuse a link-without-delay request.
- `ST_SLOT` waits for the delay-slot instruction to retire.
- `ST_HOLD_A` and `ST_HOLD_B` are the two fill cycles of the no-delay path.
- `ST_JUMP_D` redirects after the slot.
- `ST_JUMP_N` redirects and flushes without a slot.

The transitions are:
- `ST_IDLE` goes to `ST_REJECT`, `ST_SLOT` or `ST_HOLD_A` when a request is accepted.
- `ST_SLOT` goes to `ST_JUMP_D` when the slot instruction retires.
- `ST_HOLD_A` goes to `ST_HOLD_B`, and `ST_HOLD_B` goes to `ST_JUMP_N`.
- `ST_REJECT`, `ST_JUMP_D` and `ST_JUMP_N` return to `ST_IDLE`.

Top module: `ind_branch_seq`

## Requirements
- R1: A synchronous active-high `rst` sends the block to idle and drops any pending branch. In the cycle after reset, `redir_valid`, `flush`, `link_we` and `illegal_seq` are 0, and no redirect follows from a branch that was cut off.
- R2: With `br_abs`=1 the redirect PC equals `opnd_b`.
- R3: With `br_abs`=0 the redirect PC equals `cur_pc + opnd_b`, wrapped modulo 2^32.
- R4: When `br_link`=1 and `br_dly`=1, `link_we` is 1 in the redirect cycle only. `link_idx` then equals the request's `dst_idx`, and `link_data` equals the `cur_pc` of the request. `link_we` is 0 for every other request.
- R5: The request cycle is cycle 0. With `br_dly`=1 the block waits in the slot state. If `retire_valid` is first high in cycle k (k>=1), `redir_valid` is high in cycle k+1 only, with `flush`=0. With an immediate retire this gives a 2-cycle branch.
- R6: With `br_dly`=0 and `br_link`=0, `redir_valid` and `flush` are both high in cycle 3 only. This is a 3-cycle branch.
- R7: A request with `br_link`=1 and `br_dly`=0 is rejected. `illegal_seq` is high in cycle 1 only. No redirect, flush or link write follows, and the block is idle in cycle 2.
- R8: `retire_kind` is encoded as 0 = plain, 1 = immediate prefix, 2 = branch, 3 = break. A nonzero kind on the slot retire sets `illegal_seq` high together with the redirect. Kind 0 leaves it low.
- R9: `irq_ack` equals `irq_req` only when the block is idle and no request is presented that cycle. It is 0 from the request cycle through the redirect cycle.
- R10: `br_valid` raised while a branch is in progress is ignored. The redirect PC, link data and timing stay those of the accepted request.
- R11: `retire_valid` outside the slot state has no effect. In particular, on the no-delay path it neither flags illegal nor moves the redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch request present |
| br_link | input | 1 | Write return PC to destination |
| br_abs | input | 1 | 1: target is operand, 0: PC-relative |
| br_dly | input | 1 | Branch has a delay slot |
| cur_pc | input | 32 | PC of the branch instruction |
| opnd_b | input | 32 | Target operand value |
| dst_idx | input | 5 | Destination register index for the link |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_kind | input | 2 | Class of the retiring instruction |
| irq_req | input | 1 | Interrupt or hardware-break request |
| redir_valid | output | 1 | One-cycle redirect strobe |
| redir_pc | output | 32 | New PC, valid with the redirect |
| flush | output | 1 | Discard the sequentially fetched instruction |
| link_we | output | 1 | Link write enable |
| link_idx | output | 5 | Link destination index |
| link_data | output | 32 | Link value (branch PC) |
| irq_ack | output | 1 | Interrupt request accepted |
| illegal_seq | output | 1 | Illegal request or illegal slot instruction |

## Verification
The assertions assume that `retire_valid` only marks a real retirement of the instruction after the branch while the slot is pending. They also assume that an interrupt requester holds `irq_req` until it sees `irq_ack`. The stimulus keeps to both assumptions: it raises `retire_valid` once per slot, after a chosen wait of zero to two cycles, and treats `irq_req` as a level. Stray retires on the no-delay path and extra requests while busy are driven on purpose, because the block must ignore them.

// File: rtl/ind_branch_seq_pkg.sv
package ind_branch_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_REJECT = 3'd1,
        ST_SLOT   = 3'd2,
        ST_HOLD_A = 3'd3,
        ST_HOLD_B = 3'd4,
        ST_JUMP_D = 3'd5,
        ST_JUMP_N = 3'd6
    } seq_state_t;

    typedef enum logic [1:0] {
        KIND_PLAIN  = 2'd0,
        KIND_PREFIX = 2'd1,
        KIND_BRANCH = 2'd2,
        KIND_BREAK  = 2'd3
    } retire_kind_t;

endpackage

// File: rtl/ibs_target.sv
module ibs_target #(
    parameter int XLEN = 32
) (
    input  logic            abs_sel,
    input  logic [XLEN-1:0] pc_in,
    input  logic [XLEN-1:0] opnd_in,
    output logic [XLEN-1:0] tgt_out
);
    logic [XLEN-1:0] rel_sum;

    // two's-complement sum, carry out discarded (wraps at XLEN bits)
    assign rel_sum = pc_in + opnd_in;

    always_comb begin
        if (abs_sel) tgt_out = opnd_in;
        else         tgt_out = rel_sum;
    end

    always_comb begin
        assert_abs_passthru_R2: assert (!abs_sel || tgt_out == opnd_in);
    end
endmodule

// File: rtl/ibs_slot_chk.sv
module ibs_slot_chk
    import ind_branch_seq_pkg::*;
#(
    parameter int KW = 2
) (
    input  logic [KW-1:0] kind_in,
    output logic          bad_out
);
    retire_kind_t kind;

    assign kind = retire_kind_t'(kind_in);

    always_comb begin
        unique case (kind)
            KIND_PLAIN:  bad_out = 1'b0;
            KIND_PREFIX: bad_out = 1'b1;
            KIND_BRANCH: bad_out = 1'b1;
            KIND_BREAK:  bad_out = 1'b1;
            default:     bad_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/ibs_capture.sv
module ibs_capture #(
    parameter int XLEN = 32,
    parameter int RIDX = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic            slot_done,
    input  logic [XLEN-1:0] tgt_in,
    input  logic [XLEN-1:0] pc_in,
    input  logic [RIDX-1:0] idx_in,
    input  logic            link_in,
    input  logic            bad_in,
    output logic [XLEN-1:0] tgt_q,
    output logic [XLEN-1:0] pc_q,
    output logic [RIDX-1:0] idx_q,
    output logic            link_q,
    output logic            bad_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q  <= '0;
            pc_q   <= '0;
            idx_q  <= '0;
            link_q <= 1'b0;
            bad_q  <= 1'b0;
        end else begin
            if (accept) begin
                tgt_q  <= tgt_in;
                pc_q   <= pc_in;
                idx_q  <= idx_in;
                link_q <= link_in;
                bad_q  <= 1'b0;
            end
            if (slot_done) begin
                bad_q <= bad_in;
            end
        end
    end

    assert_target_held_R10: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(tgt_q));
endmodule

// File: rtl/ibs_fsm.sv
module ibs_fsm
    import ind_branch_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic br_valid,
    input  logic br_link,
    input  logic br_dly,
    input  logic retire_valid,
    input  logic irq_req,
    input  logic link_q,
    input  logic bad_q,
    output logic accept,
    output logic slot_done,
    output logic redir_valid,
    output logic flush,
    output logic link_we,
    output logic irq_ack,
    output logic illegal_seq
);
    seq_state_t st_q, st_nxt;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_nxt;
    end

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (br_valid) begin
                    if (br_link && !br_dly) st_nxt = ST_REJECT;
                    else if (br_dly)        st_nxt = ST_SLOT;
                    else                    st_nxt = ST_HOLD_A;
                end
            end
            ST_REJECT: st_nxt = ST_IDLE;
            ST_SLOT:   if (retire_valid) st_nxt = ST_JUMP_D;
            ST_HOLD_A: st_nxt = ST_HOLD_B;
            ST_HOLD_B: st_nxt = ST_JUMP_N;
            ST_JUMP_D: st_nxt = ST_IDLE;
            ST_JUMP_N: st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept      = 1'b0;
        slot_done   = 1'b0;
        redir_valid = 1'b0;
        flush       = 1'b0;
        link_we     = 1'b0;
        irq_ack     = 1'b0;
        illegal_seq = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                accept  = br_valid;
                irq_ack = irq_req && !br_valid;
            end
            ST_REJECT: illegal_seq = 1'b1;
            ST_SLOT:   slot_done = retire_valid;
            ST_HOLD_A: ;
            ST_HOLD_B: ;
            ST_JUMP_D: begin
                redir_valid = 1'b1;
                link_we     = link_q;
                illegal_seq = bad_q;
            end
            ST_JUMP_N: begin
                redir_valid = 1'b1;
                flush       = 1'b1;
            end
            default: ;
        endcase
    end

    assert_redir_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> !redir_valid);

    assert_flush_with_redir_R6: assert property (@(posedge clk) disable iff (rst)
        flush |-> redir_valid);

    assert_slot_to_redir_R5: assert property (@(posedge clk) disable iff (rst)
        slot_done |=> (redir_valid && !flush));

    assert_link_slot_path_R4: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (redir_valid && !flush));

    assert_no_irq_in_flight_R9: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (!redir_valid && !illegal_seq && !accept));

    assert_reject_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (illegal_seq && !redir_valid) |=> (!redir_valid && !illegal_seq));
endmodule

// File: rtl/ind_branch_seq.sv
module ind_branch_seq #(
    parameter int XLEN = 32,
    parameter int RIDX = 5,
    parameter int KW   = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            br_valid,
    input  logic            br_link,
    input  logic            br_abs,
    input  logic            br_dly,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] opnd_b,
    input  logic [RIDX-1:0] dst_idx,
    input  logic            retire_valid,
    input  logic [KW-1:0]   retire_kind,
    input  logic            irq_req,
    output logic            redir_valid,
    output logic [XLEN-1:0] redir_pc,
    output logic            flush,
    output logic            link_we,
    output logic [RIDX-1:0] link_idx,
    output logic [XLEN-1:0] link_data,
    output logic            irq_ack,
    output logic            illegal_seq
);
    logic [XLEN-1:0] tgt;
    logic            slot_bad;
    logic            accept;
    logic            slot_done;
    logic            link_q;
    logic            bad_q;

    ibs_target #(.XLEN(XLEN)) u_target (
        .abs_sel (br_abs),
        .pc_in   (cur_pc),
        .opnd_in (opnd_b),
        .tgt_out (tgt)
    );

    ibs_slot_chk #(.KW(KW)) u_slot (
        .kind_in (retire_kind),
        .bad_out (slot_bad)
    );

    ibs_capture #(.XLEN(XLEN), .RIDX(RIDX)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .slot_done (slot_done),
        .tgt_in    (tgt),
        .pc_in     (cur_pc),
        .idx_in    (dst_idx),
        .link_in   (br_link),
        .bad_in    (slot_bad),
        .tgt_q     (redir_pc),
        .pc_q      (link_data),
        .idx_q     (link_idx),
        .link_q    (link_q),
        .bad_q     (bad_q)
    );

    ibs_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .br_valid     (br_valid),
        .br_link      (br_link),
        .br_dly       (br_dly),
        .retire_valid (retire_valid),
        .irq_req      (irq_req),
        .link_q       (link_q),
        .bad_q        (bad_q),
        .accept       (accept),
        .slot_done    (slot_done),
        .redir_valid  (redir_valid),
        .flush        (flush),
        .link_we      (link_we),
        .irq_ack      (irq_ack),
        .illegal_seq  (illegal_seq)
    );

    assert_flush_no_link_R4: assert property (@(posedge clk) disable iff (rst)
        flush |-> !link_we);
endmodule

// File: tb/ind_branch_seq_test.sv
module ind_branch_seq_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        br_valid, br_link, br_abs, br_dly;
    logic [31:0] cur_pc, opnd_b;
    logic [4:0]  dst_idx;
    logic        retire_valid;
    logic [1:0]  retire_kind;
    logic        irq_req;
    logic        redir_valid, flush, link_we, irq_ack, illegal_seq;
    logic [31:0] redir_pc, link_data;
    logic [4:0]  link_idx;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ind_branch_seq uut (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_link(br_link),
        .br_abs(br_abs), .br_dly(br_dly), .cur_pc(cur_pc), .opnd_b(opnd_b),
        .dst_idx(dst_idx), .retire_valid(retire_valid), .retire_kind(retire_kind),
        .irq_req(irq_req), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .flush(flush), .link_we(link_we), .link_idx(link_idx),
        .link_data(link_data), .irq_ack(irq_ack), .illegal_seq(illegal_seq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pc_pick(input int i);
        case (i)
            0: return 32'hFFFF_FFF0;
            1: return 32'h0000_1000;
            2: return 32'h8000_0000;
            default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic logic [31:0] op_pick(input int i);
        case (i)
            0: return 32'h0000_0020;
            1: return 32'hFFFF_FFF8;
            2: return 32'h8000_0000;
            default: return 32'h0000_0000;
        endcase
    endfunction

    task automatic idle_inputs();
        br_valid = 0; br_link = 0; br_abs = 0; br_dly = 0;
        cur_pc = '0; opnd_b = '0; dst_idx = '0;
        retire_valid = 0; retire_kind = 0;
    endtask

    task automatic run_branch(input bit lk, input bit ab, input bit dl,
                              input int vi, input int kind, input int w, input bit irq);
        logic [31:0] pc, op, exp_tgt;
        logic [4:0]  idx;
        bit          rej;
        int          jump_cyc, last_cyc;
        pc  = pc_pick(vi);
        op  = op_pick(vi);
        idx = 5'((vi * 7 + kind * 3 + w) % 32);
        exp_tgt = ab ? op : (pc + op);
        rej = lk && !dl;
        jump_cyc = dl ? (w + 2) : 3;
        last_cyc = rej ? 2 : jump_cyc + 1;
        // cycle 0: request
        @(negedge clk);
        br_valid = 1; br_link = lk; br_abs = ab; br_dly = dl;
        cur_pc = pc; opnd_b = op; dst_idx = idx; irq_req = irq;
        retire_valid = 0;
        #1;
        chk("R9", "irq_ack on request cycle", 32'(irq_ack), 32'd0);
        for (int c = 1; c <= last_cyc; c++) begin
            @(negedge clk);
            // busy pokes with unrelated operands (R10), stray retires (R11)
            br_valid = (c < last_cyc) && !(rej && c == 2);
            br_link = ~lk; br_abs = ~ab; br_dly = ~dl;
            cur_pc = ~pc; opnd_b = op ^ 32'h5A5A_0003; dst_idx = ~idx;
            if (dl && !rej) begin
                retire_valid = (c == w + 1);
                retire_kind  = 2'(kind);
            end else begin
                retire_valid = 1; retire_kind = 2'd3;
            end
            if (c == last_cyc) begin
                br_valid = 0; retire_valid = 0;
            end
            #1;
            if (rej) begin
                if (c == 1) begin
                    chk("R7", "illegal in cycle 1", 32'(illegal_seq), 32'd1);
                    chk("R7", "no redirect on reject", 32'(redir_valid), 32'd0);
                    chk("R7", "no link on reject", 32'(link_we), 32'd0);
                    chk("R9", "irq held during reject", 32'(irq_ack), 32'd0);
                end else begin
                    chk("R7", "idle after reject", 32'(illegal_seq | redir_valid | flush), 32'd0);
                    chk("R9", "irq after reject", 32'(irq_ack), 32'(irq));
                end
            end else if (c < jump_cyc) begin
                chk(dl ? "R5" : "R6", "no early redirect", 32'(redir_valid), 32'd0);
                chk(dl ? "R8" : "R11", "no early illegal", 32'(illegal_seq), 32'd0);
                chk("R9", "irq deferred", 32'(irq_ack), 32'd0);
            end else if (c == jump_cyc) begin
                chk(dl ? "R5" : "R6", "redirect strobe", 32'(redir_valid), 32'd1);
                chk(ab ? "R2" : "R3", "redirect pc", redir_pc, exp_tgt);
                chk(dl ? "R5" : "R6", "flush", 32'(flush), 32'(!dl));
                chk("R4", "link_we", 32'(link_we), 32'(lk && dl));
                if (lk && dl) begin
                    chk("R4", "link_idx", 32'(link_idx), 32'(idx));
                    chk("R4", "link_data", link_data, pc);
                end
                chk(dl ? "R8" : "R11", "illegal with redirect", 32'(illegal_seq),
                    32'(dl && kind != 0));
                chk("R9", "irq held in redirect cycle", 32'(irq_ack), 32'd0);
            end else begin
                chk("R10", "single redirect", 32'(redir_valid), 32'd0);
                chk("R9", "irq accepted after branch", 32'(irq_ack), 32'(irq));
            end
        end
        idle_inputs();
        irq_req = 0;
    endtask

    initial begin
        idle_inputs();
        irq_req = 0;
        rst = 1;
        br_valid = 1; br_dly = 1;
        repeat (3) @(negedge clk);
        rst = 0; idle_inputs();
        #1;
        chk("R1", "redirect after reset", 32'(redir_valid), 32'd0);
        chk("R1", "flush after reset", 32'(flush), 32'd0);
        chk("R1", "link_we after reset", 32'(link_we), 32'd0);
        chk("R1", "illegal after reset", 32'(illegal_seq), 32'd0);
        irq_req = 1; #1;
        chk("R1", "irq_ack idle after reset", 32'(irq_ack), 32'd1);
        irq_req = 0;

        // reset cut a pending delay-slot branch
        @(negedge clk);
        br_valid = 1; br_dly = 1; br_link = 1; cur_pc = 32'h40; opnd_b = 32'h8;
        @(negedge clk);
        idle_inputs(); rst = 1;
        @(negedge clk);
        rst = 0; retire_valid = 1; irq_req = 1;
        #1;
        chk("R1", "idle after mid-slot reset", 32'(irq_ack), 32'd1);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk); #1;
            chk("R1", "no redirect after mid-slot reset", 32'(redir_valid | link_we), 32'd0);
        end
        idle_inputs(); irq_req = 0;

        for (int lk = 0; lk < 2; lk++)
            for (int ab = 0; ab < 2; ab++)
                for (int dl = 0; dl < 2; dl++)
                    for (int vi = 0; vi < 4; vi++)
                        for (int kd = 0; kd < 4; kd++)
                            for (int w = 0; w < 3; w++)
                                for (int iq = 0; iq < 2; iq++)
                                    run_branch(lk[0], ab[0], dl[0], vi, kd, w, iq[0]);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule